// File: doc/BRIEF.md
# Display Power Controller Serial Register Target

This block is the serial-bus target of a display power controller. It watches an I2C bus through the system clock, recognises START, repeated START and STOP, answers one fixed 7-bit address and holds a small control file. The file contains a read-only temperature byte supplied by a neighbouring measurement block, a control byte with two live bits, and an 8-bit VCOM level. The control and VCOM values are driven straight out as ports for the analog side of the chip.

A host writes by sending the device address with the direction bit low, a pointer byte, then any number of data bytes. It reads by setting the pointer that way, issuing a repeated START, and sending the address with the direction bit high. In normal operation the pointer advances after every data byte. Some display hosts can only issue bare read transfers. For them, a control bit pins every read to the temperature byte. No pointer phase is then needed and the pointer never advances on reads. The bus state machine has the states IDLE, ADDR, ADDR_ACK, PTR, PTR_ACK, WDATA, WDATA_ACK, RDATA and RACK. A START from any state enters ADDR and a STOP from any state enters IDLE. ADDR goes to ADDR_ACK on a matching address and to IDLE otherwise. ADDR_ACK goes to RDATA for reads and to PTR for writes. PTR goes to PTR_ACK, then WDATA. WDATA and WDATA_ACK alternate. RDATA goes to RACK. RACK returns to RDATA on an acknowledge and to IDLE on a not-acknowledge.

Top module: `disp_pwr_i2c`

## Requirements
- R1: After reset vcom_set_o is 0x74, vcom_src_o is 1, fix_rd_o is 0, busy_o is 0 and sda_oe_o is 0.
- R2: Only the address byte 1001000 (0x48) is acknowledged, by pulling SDA low on the ninth clock. Any other address gets no acknowledge and changes no register.
- R3: A write is address byte with R/W=0, pointer byte, then data bytes, and every byte is acknowledged. Data at register 0x01 sets fix_rd_o from bit 1 and vcom_src_o from bit 0. Data at 0x02 sets vcom_set_o.
- R4: When fix_rd_o is 0, the pointer rises by one after each data byte, read or written, and wraps from 0xFF to 0x00.
- R5: Reads return temp_i at 0x00, {000000, fix, src} at 0x01 and the VCOM byte at 0x02. Every other address reads 0x00. Bits are sent MSB first.
- R6: Writes to 0x00 or to any unmapped address are acknowledged and have no effect.
- R7: While fix_rd_o is 1, every read byte is temp_i, the pointer does not advance on reads, and writes act as in R3.
- R8: After the master answers a read byte with a not-acknowledge (SDA high), the target leaves SDA released until the next START.
- R9: sda_oe_o changes only while SCL is low. An SDA fall with SCL high is a START and an SDA rise with SCL high is a STOP.
- R10: busy_o rises on START and falls on STOP, and the target never drives SDA while not busy.
- R11: A repeated START in any phase restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| temp_i | input | 8 | Temperature byte from the measurement block |
| busy_o | output | 1 | Bus transfer in progress |
| fix_rd_o | output | 1 | Reads pinned to the temperature byte |
| vcom_src_o | output | 1 | VCOM source select |
| vcom_set_o | output | 8 | VCOM level setting |

## Verification
The bench targets pointer wrap at 0xFF, reads of unmapped and read-only addresses, and writes to them. A design that dropped the wrap or decoded only the low pointer bits would return live registers where 0x00 is due. Bare reads in pinned mode are checked across several bytes. A design that kept advancing would leak the control byte. Repeated START after a pointer write, a foreign address, and release of SDA after a not-acknowledge are each checked. A design that got these wrong would corrupt later transfers or hold the bus low.

// File: rtl/dpi2c_pkg.sv
package dpi2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/dpi2c_sync.sv
module dpi2c_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/dpi2c_cond.sv
module dpi2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/dpi2c_regs.sv
module dpi2c_regs #(
    parameter int         DW       = 8,
    parameter logic [7:0] VCOM_RST = 8'h74,
    parameter logic [1:0] CTL_RST  = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_addr,
    input  logic [DW-1:0] temp_i,
    output logic [DW-1:0] rd_data,
    output logic          fix_o,
    output logic          src_o,
    output logic [DW-1:0] vcom_o
);

    localparam logic [DW-1:0] A_TEMP = DW'(0);
    localparam logic [DW-1:0] A_CTL  = DW'(1);
    localparam logic [DW-1:0] A_VCOM = DW'(2);

    logic [1:0]    ctl_q;
    logic [DW-1:0] vcom_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RST;
            vcom_q <= DW'(VCOM_RST);
        end else if (wr_en) begin
            if (wr_addr == A_CTL)  ctl_q  <= wr_data[1:0];
            if (wr_addr == A_VCOM) vcom_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_TEMP)      rd_data = temp_i;
        else if (rd_addr == A_CTL)  rd_data = {{(DW-2){1'b0}}, ctl_q};
        else if (rd_addr == A_VCOM) rd_data = vcom_q;
    end

    assign fix_o  = ctl_q[1];
    assign src_o  = ctl_q[0];
    assign vcom_o = vcom_q;

endmodule

// File: rtl/disp_pwr_i2c.sv
module disp_pwr_i2c
    import dpi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [BYTE_W-1:0] temp_i,
    output logic              busy_o,
    output logic              fix_rd_o,
    output logic              vcom_src_o,
    output logic [BYTE_W-1:0] vcom_set_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, txbyte, ptr, rd_data;
    logic              rw_q, nack_q, busy_q, wr_en;
    logic              byte_in_done;

    dpi2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    dpi2c_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpi2c_regs #(.DW(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (shreg),
        .rd_addr (fix_rd_o ? '0 : ptr),
        .temp_i  (temp_i),
        .rd_data (rd_data),
        .fix_o   (fix_rd_o),
        .src_o   (vcom_src_o),
        .vcom_o  (vcom_set_o)
    );

    assign byte_in_done = scl_fall && (cnt == LAST_BIT);
    assign wr_en = (state == ST_WDATA) && byte_in_done && !start_det && !stop_det;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_in_done)
                                  state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_in_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_in_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && cnt == LAST_TX) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall) state_nx = nack_q ? ST_IDLE : ST_RDATA;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath: shifter, counter, pointer, busy flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            txbyte <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b1;
            busy_q <= 1'b0;
        end else if (start_det) begin
            cnt    <= '0;
            busy_q <= 1'b1;
        end else if (stop_det) begin
            busy_q <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_in_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR)  rw_q <= shreg[0];
                        if (state == ST_PTR)   ptr  <= shreg;
                        if (state == ST_WDATA) ptr  <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        txbyte <= rd_data;
                        cnt    <= '0;
                        if (!fix_rd_o) ptr <= ptr + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
                        cnt    <= cnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_s;
                    end else if (scl_fall && !nack_q) begin
                        txbyte <= rd_data;
                        cnt    <= '0;
                        if (!fix_rd_o) ptr <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                              sda_oe_o = ~txbyte[BYTE_W-1];
            default:                               sda_oe_o = 1'b0;
        endcase
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/dpi2c_checker.sv
module dpi2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       busy_o,
    input logic       fix_rd_o,
    input logic [7:0] vcom_set_o
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i); // R9

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sda_oe_o); // R10

    AST_VCOM_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(vcom_set_o)); // R3

    AST_FIX_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(fix_rd_o)); // R7

endmodule

bind disp_pwr_i2c dpi2c_checker i_dpi2c_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .fix_rd_o   (fix_rd_o),
    .vcom_set_o (vcom_set_o)
);

// File: tb/test_disp_pwr_i2c.sv
module test_disp_pwr_i2c;

    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'h48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] temp = 8'h19;
    logic sda_oe, busy, fix_rd, vsrc;
    logic [7:0] vcom;
    wire sda_bus = m_sda & ~sda_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_vcom = 8'h74;
    logic m_fix = 1'b0, m_src = 1'b1;
    logic [7:0] m_ptr = 8'h00;

    always #10 clk = ~clk;

    disp_pwr_i2c i_disp_pwr_i2c (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .temp_i     (temp),
        .busy_o     (busy),
        .fix_rd_o   (fix_rd),
        .vcom_src_o (vsrc),
        .vcom_set_o (vcom)
    );

    function automatic logic [7:0] mread(input logic [7:0] a);
        case (a)
            8'h00:   return temp;
            8'h01:   return {6'b0, m_fix, m_src};
            8'h02:   return m_vcom;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void mwrite(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h01) begin m_fix = d[1]; m_src = d[0]; end
        if (a == 8'h02) m_vcom = d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
        chk(busy == 1'b1, "R10 busy after START", busy, 1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
        wt(4);
        chk(busy == 1'b0, "R10 idle after STOP", busy, 0);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        b = sda_bus; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic send(input logic [7:0] d, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv(output logic [7:0] d, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(!give_ack);
    endtask

    task automatic check_ports(input string tag);
        chk(vcom == m_vcom, {tag, " vcom"}, vcom, m_vcom);
        chk({fix_rd, vsrc} == {m_fix, m_src}, {tag, " ctl"}, {fix_rd, vsrc}, {m_fix, m_src});
    endtask

    // R3 R4 R6: pointer then a burst of data
    task automatic do_write(input logic [7:0] p, input int n, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2);
        bit ack;
        logic [7:0] dv;
        bus_start();
        send({DEV, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
        send(p, ack);           chk(ack, "R3 ptr ack", ack, 1);
        m_ptr = p;
        for (int i = 0; i < n; i++) begin
            dv = (i == 0) ? d0 : (i == 1) ? d1 : d2;
            send(dv, ack); chk(ack, "R3 data ack", ack, 1);
            mwrite(m_ptr, dv);
            m_ptr = m_ptr + 8'd1;
        end
        bus_stop();
        check_ports("R3");
    endtask

    // R5 R4 R7 R11: pointer write, repeated START, burst read
    task automatic do_read(input logic [7:0] p, input int n, input string tag);
        bit ack;
        logic [7:0] got, exp;
        bus_start();
        send({DEV, 1'b0}, ack); chk(ack, "R11 addr ack", ack, 1);
        send(p, ack);           chk(ack, "R11 ptr ack", ack, 1);
        m_ptr = p;
        bus_start();
        send({DEV, 1'b1}, ack); chk(ack, "R11 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp = m_fix ? temp : mread(m_ptr);
            if (!m_fix) m_ptr = m_ptr + 8'd1;
            recv(got, i != n - 1);
            chk(got == exp, tag, got, exp);
        end
        wt(2);
        chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R8 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    // R7: bare read with no pointer phase
    task automatic do_bare_read(input int n);
        bit ack;
        logic [7:0] got, exp;
        bus_start();
        send({DEV, 1'b1}, ack); chk(ack, "R7 bare addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp = m_fix ? temp : mread(m_ptr);
            if (!m_fix) m_ptr = m_ptr + 8'd1;
            recv(got, i != n - 1);
            chk(got == exp, "R7 bare read", got, exp);
        end
        bus_stop();
    endtask

    task automatic do_foreign(input logic [6:0] a);
        bit ack;
        bus_start();
        send({a, 1'b0}, ack); chk(!ack, "R2 foreign addr nack", ack, 0);
        send(8'h02, ack);     chk(!ack, "R2 ignored after foreign", ack, 0);
        send(8'h00, ack);
        bus_stop();
        check_ports("R2");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        int kind;
        seed = 32'h5eed;
        void'($urandom(seed));
        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk(vcom == 8'h74, "R1 vcom reset", vcom, 8'h74);
        chk(vsrc == 1'b1 && fix_rd == 1'b0, "R1 ctl reset", {fix_rd, vsrc}, 1);
        chk(busy == 1'b0 && sda_oe == 1'b0, "R1 bus reset", {busy, sda_oe}, 0);

        do_read(8'h00, 4, "R5 R4 burst from 0");
        do_write(8'h02, 1, 8'h5A, 8'h00, 8'h00);
        do_read(8'h02, 1, "R5 vcom readback");
        do_write(8'h00, 1, 8'hEE, 8'h00, 8'h00);
        do_read(8'h00, 1, "R6 temp not writable");
        do_write(8'h10, 1, 8'h33, 8'h00, 8'h00);
        do_read(8'h10, 1, "R6 R5 unmapped reads 0");
        do_write(8'hFF, 3, 8'h11, 8'h22, 8'h02);
        do_read(8'hFE, 4, "R4 pointer wrap");
        do_foreign(7'h49);
        do_foreign(7'h08);
        do_write(8'h01, 1, 8'h03, 8'h00, 8'h00);
        temp = 8'hF6;
        do_bare_read(3);
        do_read(8'h02, 2, "R7 pinned ignores pointer");
        do_write(8'h02, 1, 8'h1C, 8'h00, 8'h00);
        do_write(8'h01, 2, 8'h00, 8'hE8, 8'h00);
        do_read(8'h01, 2, "R5 after unpin");

        for (int t = 0; t < 30; t++) begin
            kind = $urandom_range(0, 4);
            temp = 8'($urandom);
            case (kind)
                0: do_write(8'($urandom_range(0, 3)), $urandom_range(1, 3),
                            8'($urandom), 8'($urandom), 8'($urandom));
                1: do_read(8'($urandom_range(0, 4)), $urandom_range(1, 3), "R5 random read");
                2: do_bare_read($urandom_range(1, 3));
                3: do_write(8'h01, 1, {6'($urandom), 1'($urandom), 1'($urandom)}, 8'h00, 8'h00);
                default: do_foreign(7'($urandom_range(0, 71)));
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule